// File: doc/BRIEF.md
# Status Register and Write-Permission Arbiter

This block sits beside the write engine of a serial nonvolatile memory. It holds the status byte that the host reads back, and for each write request it decides in the same cycle whether the write may go ahead. A request targets either the status byte or one array address. The block combines four things to reach that decision:

- the write-enable latch, which the set and clear strobes control;
- the two block-protect bits, which cover the top quarter, the top half or the whole array;
- a lock-enable bit that works with an active-low lock pin;
- the busy flag of the write engine.

The write engine acts only on a granted request. The three nonvolatile bits are ordinary flops that the block reset clears, which models a blank part.

Top module: `wp_status_arbiter`

## Requirements
- R1: The status byte is laid out as bit 7 = lock-enable, bits 6 to 4 = constant 0, bit 3 = protect-high, bit 2 = protect-low, bit 1 = write-enable latch, bit 0 = busy.
- R2: Status bit 0 equals `engineBusy` in the same cycle. No request or data byte changes it.
- R3: A `wrEnStb` pulse sets the latch from the next cycle on, and a `wrDisStb` pulse clears it. When both pulse in the same cycle, the clear wins.
- R4: For the top two address bits `t`, protect code 0 covers no address, code 1 covers `t == 3`, code 2 covers `t >= 2`, and code 3 covers every address. An array request to a covered address is never granted.
- R5: The hardware lock is on when lock-enable is 1 and `wpPinN` is 0. While it is on, status requests are denied, and array requests to uncovered addresses are still granted if the latch is 1.
- R6: While the latch is 0, no request of either kind is granted.
- R7: A grant is raised only in a cycle with `reqValid` high. It goes to `grantStatus` when `reqIsStatus` is 1 and to `grantArray` otherwise. With the latch at 1 and no lock, status requests and uncovered array requests are granted.
- R8: A granted status request loads data bits 7, 3 and 2 into status bits 7, 3 and 2, visible from the next cycle. The other status bits ignore the data byte.
- R9: A denied request leaves the lock-enable bit, the protect bits and the latch unchanged.
- R10: While `engineBusy` is 1, no request is granted.
- R11: After reset, status bits 7 to 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEnStb | input | 1 | Sets the write-enable latch |
| wrDisStb | input | 1 | Clears the write-enable latch |
| reqValid | input | 1 | A write request is present this cycle |
| reqIsStatus | input | 1 | 1 = the request targets the status byte, 0 = the array |
| reqAddr | input | ADDR_W | Array address of the request |
| reqData | input | 8 | Data byte for a status request |
| wpPinN | input | 1 | Active-low hardware lock pin |
| engineBusy | input | 1 | The write engine is busy |
| statusByte | output | 8 | Readable status byte |
| grantArray | output | 1 | The array write is permitted |
| grantStatus | output | 1 | The status write is permitted |

## Verification
The assertions rely on each request being a single-cycle, registered event. They also rely on `reqAddr`, `reqIsStatus` and `wpPinN` being stable for the whole cycle in which the grant is sampled. The bench meets both conditions by changing every input only at the falling clock edge, from one driving loop. The assertions take no position on whether strobes and requests may overlap. The stimulus therefore does combine them, including set and clear together and a strobe in the same cycle as a status request, so that the priorities are exercised.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;
  typedef struct packed {
    logic       setWel;
    logic       clrWel;
    logic       loadNv;
    logic       lockEnNext;
    logic [1:0] bpNext;
  } regStrobe_t;

  localparam int unsigned STATUS_W = 8;
  localparam int unsigned NUM_CODES = 4;

  // quarter index at and above which a protect code covers the array
  function automatic int unsigned firstCoveredQuarter(input int unsigned code);
    case (code)
      1: return 3;
      2: return 2;
      3: return 0;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wp_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnStb,
  input  logic              wrDisStb,
  input  logic              reqValid,
  input  logic              reqIsStatus,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              wpPinN,
  input  logic              engineBusy,
  input  logic              wel,
  input  logic              lockEn,
  input  logic [1:0]        bp,
  output logic              grantArray,
  output logic              grantStatus,
  output regStrobe_t        strb
);
  localparam int unsigned TOP_LSB = ADDR_W - 2;

  logic [1:0] topQuarter;
  logic [NUM_CODES-1:0] codeCovers;
  logic covered;
  logic hwLock;
  logic mayWrite;
  logic unusedLowBits;

  assign topQuarter    = reqAddr[ADDR_W-1:TOP_LSB];
  assign unusedLowBits = ^{reqAddr[TOP_LSB-1:0], reqData[6:4], reqData[1:0]};

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    localparam int unsigned FIRST_Q = firstCoveredQuarter(c);
    assign codeCovers[c] = (32'(topQuarter) >= FIRST_Q);
  end

  assign covered  = codeCovers[bp];
  assign hwLock   = lockEn && !wpPinN;
  assign mayWrite = reqValid && wel && !engineBusy;

  assign grantStatus = mayWrite && reqIsStatus && !hwLock;
  assign grantArray  = mayWrite && !reqIsStatus && !covered;

  always_comb begin
    strb.setWel     = wrEnStb;
    strb.clrWel     = wrDisStb;
    strb.loadNv     = grantStatus;
    strb.lockEnNext = reqData[7];
    strb.bpNext     = reqData[3:2];
  end

  p_lock_blocks_status_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockEn && !wpPinN) |-> !grantStatus);
  p_no_grant_without_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wel |-> !(grantArray || grantStatus));
  p_busy_denies_r10: assert property (@(posedge clk) disable iff (!rstN)
    engineBusy |-> !(grantArray || grantStatus));
  p_full_cover_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bp == 2'b11) |-> !grantArray);
  p_grant_needs_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(grantArray || grantStatus));
endmodule

// File: rtl/wp_status_regs.sv
module wp_status_regs
  import wp_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t strb,
  input  logic       engineBusy,
  output logic       wel,
  output logic       lockEn,
  output logic [1:0] bp,
  output logic [7:0] statusByte
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
    end else if (strb.clrWel) begin
      wel <= 1'b0;
    end else if (strb.setWel) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockEn <= 1'b0;
      bp     <= 2'b00;
    end else if (strb.loadNv) begin
      lockEn <= strb.lockEnNext;
      bp     <= strb.bpNext;
    end
  end

  assign statusByte = {lockEn, 3'b000, bp, wel, engineBusy};

  p_wel_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWel |=> !wel);
  p_wel_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setWel && !strb.clrWel) |=> wel);
  p_wel_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setWel && !strb.clrWel) |=> $stable(wel));
  p_nv_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadNv |=> ($stable(lockEn) && $stable(bp)));
  p_nv_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadNv |=> (lockEn == $past(strb.lockEnNext) && bp == $past(strb.bpNext)));
endmodule

// File: rtl/wp_status_arbiter.sv
module wp_status_arbiter
  import wp_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnStb,
  input  logic              wrDisStb,
  input  logic              reqValid,
  input  logic              reqIsStatus,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              wpPinN,
  input  logic              engineBusy,
  output logic [7:0]        statusByte,
  output logic              grantArray,
  output logic              grantStatus
);
  regStrobe_t strb;
  logic       wel;
  logic       lockEn;
  logic [1:0] bp;

  wp_status_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEnStb(wrEnStb), .wrDisStb(wrDisStb),
    .reqValid(reqValid), .reqIsStatus(reqIsStatus),
    .reqAddr(reqAddr), .reqData(reqData),
    .wpPinN(wpPinN), .engineBusy(engineBusy),
    .wel(wel), .lockEn(lockEn), .bp(bp),
    .grantArray(grantArray), .grantStatus(grantStatus),
    .strb(strb)
  );

  wp_status_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .engineBusy(engineBusy),
    .wel(wel), .lockEn(lockEn), .bp(bp), .statusByte(statusByte)
  );

  p_busy_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] == engineBusy);
endmodule

// File: tb/wp_status_arbiter_tb.sv
module wp_status_arbiter_tb;
  localparam int unsigned ADDR_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEnStb = 0, wrDisStb = 0, reqValid = 0, reqIsStatus = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic wpPinN = 1'b1, engineBusy = 1'b0;
  logic [7:0] statusByte;
  logic grantArray, grantStatus;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int mWel = 0, mLock = 0, mBp = 0;
  bit lastDenied = 0;

  always #4 clk = ~clk;

  wp_status_arbiter #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEnStb(wrEnStb), .wrDisStb(wrDisStb),
    .reqValid(reqValid), .reqIsStatus(reqIsStatus), .reqAddr(reqAddr),
    .reqData(reqData), .wpPinN(wpPinN), .engineBusy(engineBusy),
    .statusByte(statusByte), .grantArray(grantArray), .grantStatus(grantStatus)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int covers(input int bpCode, input int addr);
    int t = addr >> (ADDR_W - 2);
    case (bpCode)
      1: return (t == 3) ? 1 : 0;
      2: return (t >= 2) ? 1 : 0;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  // drive at falling edge, compare 2 ns later, then advance the model
  task automatic step(input bit en, input bit dis, input bit v, input bit st,
                      input int addr, input int data, input bit pin, input bit busy);
    int expGs, expGa, lock;
    string tg;
    @(negedge clk);
    wrEnStb = en; wrDisStb = dis; reqValid = v; reqIsStatus = st;
    reqAddr = addr[ADDR_W-1:0]; reqData = data[7:0]; wpPinN = pin; engineBusy = busy;
    #2;
    lock  = (mLock == 1 && !pin) ? 1 : 0;
    expGs = (v && st && mWel == 1 && !busy && !lock) ? 1 : 0;
    expGa = (v && !st && mWel == 1 && !busy && covers(mBp, addr) == 0) ? 1 : 0;
    if (!v) tg = "R7";
    else if (busy) tg = "R10";
    else if (mWel == 0) tg = "R6";
    else if (st && lock) tg = "R5";
    else if (!st && covers(mBp, addr) == 1) tg = "R4";
    else tg = "R7";
    check({tg, " grantStatus"}, int'(grantStatus), expGs);
    check({tg, " grantArray"}, int'(grantArray), expGa);
    check("R2 busy bit", int'(statusByte[0]), int'(busy));
    check("R1 zero bits", int'(statusByte[6:4]), 0);
    check(lastDenied ? "R9 latch" : "R3 latch", int'(statusByte[1]), mWel);
    check(lastDenied ? "R9 nv bits" : "R8 nv bits",
          int'({statusByte[7], statusByte[3:2]}), (mLock << 2) | mBp);
    lastDenied = v && !(expGs || expGa);
    if (expGs == 1) begin
      mLock = (data >> 7) & 1;
      mBp   = (data >> 2) & 3;
    end
    if (dis) mWel = 0;
    else if (en) mWel = 1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    check("R11 reset status", int'(statusByte[7:1]), 0);
    // latch 0: all denied
    step(0,0,1,1,0,8'h8C,1,0);
    step(0,0,1,0,12'h123,0,1,0);
    // set latch, cover top quarter
    step(1,0,0,0,0,0,1,0);
    step(0,0,1,1,0,8'h04,1,0);
    step(0,0,1,0,12'hBFF,0,1,0);
    step(0,0,1,0,12'hC00,0,1,0);
    // half
    step(0,0,1,1,0,8'h08,1,0);
    step(0,0,1,0,12'h7FF,0,1,0);
    step(0,0,1,0,12'h800,0,1,0);
    // whole, then back to none with data noise in other bits
    step(0,0,1,1,0,8'h0C,1,0);
    step(0,0,1,0,12'h000,0,1,0);
    step(0,0,1,1,0,8'h73,1,0);
    // busy denies
    step(0,0,1,0,12'h010,0,1,1);
    step(0,0,1,1,0,8'h8C,1,1);
    // lock enable with quarter cover, pin low
    step(0,0,1,1,0,8'h84,1,0);
    step(0,0,1,1,0,8'h00,0,0);
    step(0,0,1,0,12'h100,0,0,0);
    step(0,0,1,0,12'hFFF,0,0,0);
    // pin high releases lock
    step(0,0,1,1,0,8'h00,1,0);
    // both strobes: clear wins
    step(1,1,0,0,0,0,1,0);
    step(0,0,1,0,12'h001,0,1,0);
    // strobe together with a status request
    step(1,0,1,1,0,8'h88,1,0);
    step(0,1,1,1,0,8'h00,1,0);
    step(0,0,1,1,0,8'h00,1,0);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      step(r[0] & r[1], r[2] & r[3] & r[4], r[5], r[6], $urandom % 4096,
           $urandom % 256, r[7] | r[8], r[9] & r[10] & r[11]);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule